// File: doc/BRIEF.md
# I2C Target Engine with Host-Handshake Clock Stretching

This block is the bus-facing half of an I2C target. It oversamples the SCL and SDA lines on the system clock and recognises START, repeated START and STOP. After each START it shifts in one address byte and compares its upper seven bits with a programmable own address. It drives both lines only through open-drain enables, where a 1 pulls the line low. When the host side has to make a decision, the block holds SCL low, and it keeps holding it until the host responds. The decisions are whether to acknowledge an address or a received byte, and what byte to send next.

The host side has three sticky flags: address matched, byte ready and stop seen. Each flag is cleared by a one-cycle write-one pulse. The host side also sees the transfer direction, a collision status, the received byte and a transmit data register. An acknowledge-action input selects whether the next acknowledge the target drives is an ACK or a NACK. A mode input selects where the address stretch happens. In one mode the target acknowledges on its own and then stretches. In the other it stretches before the acknowledge bit and drives that bit only once the host answers.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset both open-drain enables are low and the address-match, byte-ready, stop, direction and collision outputs are all 0.
- R2: If the seven upper bits of the byte after a START differ from `own_addr_i`, the target does not drive SDA, raises no flag and ignores all bus activity until the next START. A STOP that follows does not set the stop flag.
- R3: With `stretch_after_ack_i`=1, a matching address is acknowledged at once using `ack_nack_i` (0 drives ACK, i.e. SDA low; 1 sends NACK). The address-match flag is then set and SCL is held low until the host clears that flag.
- R4: With `stretch_after_ack_i`=0, the address-match flag is set after the eighth address bit and SCL is held low with SDA released. The acknowledge bit, chosen by `ack_nack_i`, is driven only after `clr_amatch_i` or `cmd_ack_i`.
- R5: `dir_o` takes bit 0 of the address byte (1 = the controller reads) and changes only when an address matches.
- R6: In a write transfer, each byte is shifted in MSB first and shown on `rx_data_o` when `drdy_o` rises. SCL is then held low until `clr_drdy_i` or `cmd_ack_i`, after which the acknowledge chosen by `ack_nack_i` is driven.
- R7: In a read transfer, the byte held in the transmit register is sent MSB first. `drdy_o` is set after the controller's acknowledge bit. On ACK, SCL is held until `clr_drdy_i` and the transmit register then supplies the next byte. On NACK, both lines are released and the bus is ignored until STOP or a repeated START.
- R8: A STOP seen after a matching address sets `stop_o` and returns the target to idle.
- R9: A collision is SDA sampled low on a rising SCL edge while the target is releasing SDA to send a 1. It releases both lines at once, raises no flag and sets `coll_o`. `coll_o` is still set at the next address match and is cleared when the host clears that address-match flag.
- R10: Every flag clear that ends a stretch releases SCL on the next system clock cycle.
- R11: A repeated START, seen in any state, starts a new address phase. A new matching address updates the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Seven-bit target address |
| stretch_after_ack_i | input | 1 | 1: auto-acknowledge address then stretch; 0: stretch before acknowledge |
| ack_nack_i | input | 1 | Acknowledge action: 0 ACK, 1 NACK |
| cmd_ack_i | input | 1 | Pulse: send the pending acknowledge |
| clr_amatch_i | input | 1 | Pulse: clear address-match flag |
| clr_drdy_i | input | 1 | Pulse: clear byte-ready flag |
| clr_stop_i | input | 1 | Pulse: clear stop flag |
| tx_we_i | input | 1 | Pulse: write the transmit register |
| tx_data_i | input | 8 | Transmit register write data |
| rx_data_o | output | 8 | Last received byte |
| amatch_o | output | 1 | Address-match flag |
| drdy_o | output | 1 | Byte-ready flag |
| stop_o | output | 1 | Stop-seen flag |
| dir_o | output | 1 | Direction of the matched transfer, 1 = read |
| coll_o | output | 1 | Collision status |

## Verification
The bench targets the corner cases below. It changes the stretch mode between transfers and checks that SDA stays released during a before-acknowledge stretch, which catches a design that acknowledges too early. It sends a non-matching address that carries the read bit, so a design that updated the direction without a match would report a read. It ends a read with a controller NACK and then clocks a further byte, so a target that kept driving would corrupt that byte. It also forces a collision on a transmitted 1 and then reads `coll_o` at the next address match and again after the flag is cleared, which exposes a status bit that is lost early or never cleared.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AWAIT,   // stretch before address acknowledge
    ST_AACK,    // driving address acknowledge bit
    ST_AHOLD,   // stretch after address acknowledge
    ST_RX,
    ST_RHOLD,
    ST_RACK,
    ST_TX,
    ST_TACK,    // sampling controller acknowledge
    ST_THOLD,
    ST_WAIT     // ignore bus until STOP / repeated START
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges qualified by SCL high in both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              stretch_after_ack_i,
  input  logic              ack_nack_i,
  input  logic              cmd_ack_i,
  input  logic              clr_amatch_i,
  input  logic              clr_drdy_i,
  input  logic              clr_stop_i,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              amatch_o,
  output logic              drdy_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic              coll_o,
  output tgt_state_e        state_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_sr_q, tx_sr_q, tx_buf_q, rx_q;
  logic              ack_drv_q, mack_q;
  logic              amatch_q, drdy_q, stop_q, dir_q, coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      tx_buf_q  <= '0;
      rx_q      <= '0;
      ack_drv_q <= 1'b0;
      mack_q    <= 1'b1;
      amatch_q  <= 1'b0;
      drdy_q    <= 1'b0;
      stop_q    <= 1'b0;
      dir_q     <= 1'b0;
      coll_q    <= 1'b0;
    end else begin
      if (clr_stop_i)   stop_q   <= 1'b0;
      if (clr_drdy_i)   drdy_q   <= 1'b0;
      if (clr_amatch_i) amatch_q <= 1'b0;
      if (clr_amatch_i && amatch_q) coll_q <= 1'b0;
      if (tx_we_i)      tx_buf_q <= tx_data_i;

      if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        ack_drv_q <= 1'b0;
      end else if (stop_i) begin
        if (state_q != ST_IDLE && state_q != ST_ADDR) stop_q <= 1'b1;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              rx_sr_q <= {rx_sr_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (state_q == ST_RX) begin
                rx_q    <= rx_sr_q;
                drdy_q  <= 1'b1;
                state_q <= ST_RHOLD;
              end else if (rx_sr_q[BYTE_W-1:1] == own_addr_i) begin
                dir_q <= rx_sr_q[0];
                if (stretch_after_ack_i) begin
                  ack_drv_q <= ~ack_nack_i;
                  state_q   <= ST_AACK;
                end else begin
                  amatch_q <= 1'b1;
                  state_q  <= ST_AWAIT;
                end
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AWAIT: begin
            if (clr_amatch_i || cmd_ack_i) begin
              amatch_q  <= 1'b0;
              ack_drv_q <= ~ack_nack_i;
              state_q   <= ST_AACK;
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (stretch_after_ack_i) begin
                amatch_q <= 1'b1;
                state_q  <= ST_AHOLD;
              end else if (!ack_drv_q) begin
                state_q <= ST_IDLE;
              end else if (dir_q) begin
                tx_sr_q <= tx_buf_q;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_AHOLD: begin
            if (clr_amatch_i) begin
              cnt_q <= '0;
              if (!ack_drv_q) begin
                state_q <= ST_IDLE;
              end else if (dir_q) begin
                tx_sr_q <= tx_buf_q;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_RHOLD: begin
            if (clr_drdy_i || cmd_ack_i) begin
              drdy_q    <= 1'b0;
              ack_drv_q <= ~ack_nack_i;
              state_q   <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall_i) state_q <= ST_RX;
          end
          ST_TX: begin
            if (scl_rise_i) begin
              if (tx_sr_q[BYTE_W-1] && !sda_s_i) begin
                coll_q  <= 1'b1;
                state_q <= ST_WAIT;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else if (scl_fall_i) begin
              if (cnt_q == LAST_BIT) begin
                cnt_q   <= '0;
                state_q <= ST_TACK;
              end else begin
                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b1};
              end
            end
          end
          ST_TACK: begin
            if (scl_rise_i) begin
              mack_q <= sda_s_i;
            end else if (scl_fall_i) begin
              drdy_q  <= 1'b1;
              state_q <= mack_q ? ST_WAIT : ST_THOLD;
            end
          end
          ST_THOLD: begin
            if (clr_drdy_i) begin
              tx_sr_q <= tx_buf_q;
              cnt_q   <= '0;
              state_q <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_AACK, ST_RACK: sda_oe_o = ack_drv_q;
      ST_TX:            sda_oe_o = ~tx_sr_q[BYTE_W-1];
      default:          sda_oe_o = 1'b0;
    endcase
  end

  assign scl_oe_o  = (state_q == ST_AWAIT) || (state_q == ST_AHOLD) ||
                     (state_q == ST_RHOLD) || (state_q == ST_THOLD);
  assign rx_data_o = rx_q;
  assign amatch_o  = amatch_q;
  assign drdy_o    = drdy_q;
  assign stop_o    = stop_q;
  assign dir_o     = dir_q;
  assign coll_o    = coll_q;
  assign state_o   = state_q;
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              stretch_after_ack_i,
  input  logic              ack_nack_i,
  input  logic              cmd_ack_i,
  input  logic              clr_amatch_i,
  input  logic              clr_drdy_i,
  input  logic              clr_stop_i,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              amatch_o,
  output logic              drdy_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic              coll_o
);
  logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  tgt_state_e core_state;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_tgt_core u_core (
    .clk_i               (clk_i),
    .rst_ni              (rst_ni),
    .sda_s_i             (sda_s),
    .scl_rise_i          (scl_rise),
    .scl_fall_i          (scl_fall),
    .start_i             (bus_start),
    .stop_i              (bus_stop),
    .own_addr_i          (own_addr_i),
    .stretch_after_ack_i (stretch_after_ack_i),
    .ack_nack_i          (ack_nack_i),
    .cmd_ack_i           (cmd_ack_i),
    .clr_amatch_i        (clr_amatch_i),
    .clr_drdy_i          (clr_drdy_i),
    .clr_stop_i          (clr_stop_i),
    .tx_we_i             (tx_we_i),
    .tx_data_i           (tx_data_i),
    .scl_oe_o            (scl_oe_o),
    .sda_oe_o            (sda_oe_o),
    .rx_data_o           (rx_data_o),
    .amatch_o            (amatch_o),
    .drdy_o              (drdy_o),
    .stop_o              (stop_o),
    .dir_o               (dir_o),
    .coll_o              (coll_o),
    .state_o             (core_state)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_i,
  input logic       sda_oe_i,
  input logic       amatch_i,
  input logic       drdy_i,
  input logic       stop_i,
  input logic       dir_i,
  input logic       coll_i,
  input logic       clr_amatch_i,
  input tgt_state_e state_i
);
  // R3 / R4 / R6 / R7: a stretch always has a pending flag behind it
  assert_stretch_has_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_i |-> (amatch_i || drdy_i));

  assert_clear_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_AWAIT || state_i == ST_AHOLD) && clr_amatch_i) |=> !scl_oe_i);

  assert_coll_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_i) |-> (!sda_oe_i && !scl_oe_i && !$rose(amatch_i) && !$rose(drdy_i)));

  assert_dir_on_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_i) |-> ($past(state_i) == ST_ADDR));

  assert_stop_to_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_i) |-> (state_i == ST_IDLE));
endmodule

bind i2c_tgt_stretch i2c_tgt_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_oe_i     (scl_oe_o),
  .sda_oe_i     (sda_oe_o),
  .amatch_i     (amatch_o),
  .drdy_i       (drdy_o),
  .stop_i       (stop_o),
  .dir_i        (dir_o),
  .coll_i       (coll_o),
  .clr_amatch_i (clr_amatch_i),
  .state_i      (core_state)
);

// File: tb/i2c_tgt_stretch_bench.sv
module i2c_tgt_stretch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP   = 12;  // half SCL period in system clocks
  localparam int HOLD = 25;  // host response delay

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe;
  logic [6:0] own_addr = 7'h2A;
  logic stretch_after = 1'b1, ack_nack = 1'b0, cmd_ack = 1'b0;
  logic clr_amatch = 1'b0, clr_drdy = 1'b0, clr_stop = 1'b0, tx_we = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic amatch, drdy, stop_f, dir, coll;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_tgt_stretch u_i2c_tgt_stretch (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
    .stretch_after_ack_i(stretch_after), .ack_nack_i(ack_nack), .cmd_ack_i(cmd_ack),
    .clr_amatch_i(clr_amatch), .clr_drdy_i(clr_drdy), .clr_stop_i(clr_stop),
    .tx_we_i(tx_we), .tx_data_i(tx_data), .rx_data_o(rx_data),
    .amatch_o(amatch), .drdy_o(drdy), .stop_o(stop_f), .dir_o(dir), .coll_o(coll)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tx_q[$];
  bit auto_en = 1'b0;
  bit coll_at_match = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b;
    wait_n(HP);
    m_scl = 1'b1;
    wait_scl_high();
    wait_n(HP/2);
    r = sda_bus;
    wait_n(HP/2);
    m_scl = 1'b0;
    wait_n(HP);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1;
    wait_n(HP);
    m_sda = 1'b0;
    wait_n(HP);
    m_scl = 1'b0;
    wait_n(HP);
  endtask

  task automatic m_rstart();
    m_sda = 1'b1;
    wait_n(HP);
    m_scl = 1'b1;
    wait_scl_high();
    wait_n(HP);
    m_sda = 1'b0;
    wait_n(HP);
    m_scl = 1'b0;
    wait_n(HP);
  endtask

  task automatic m_stop();
    m_sda = 1'b0;
    wait_n(HP);
    m_scl = 1'b1;
    wait_scl_high();
    wait_n(HP);
    m_sda = 1'b1;
    wait_n(HP);
  endtask

  task automatic m_write(input logic [7:0] b, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic m_read(input bit give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(give_ack ? 1'b0 : 1'b1, r);
  endtask

  task automatic pulse_clr_stop();
    clr_stop = 1'b1;
    @(negedge clk);
    clr_stop = 1'b0;
  endtask

  // host responder
  initial begin
    forever begin
      @(negedge clk);
      if (auto_en && amatch) begin
        wait_n(HOLD);
        chk(scl_oe == 1'b1, "R3/R4 address stretch held", scl_oe, 1);
        chk(sda_oe == 1'b0, "R4 SDA released while stretched", sda_oe, 0);
        coll_at_match = coll;
        if (dir) begin
          tx_data = (tx_q.size() != 0) ? tx_q.pop_front() : 8'h00;
          tx_we = 1'b1;
          @(negedge clk);
          tx_we = 1'b0;
        end
        clr_amatch = 1'b1;
        @(negedge clk);
        clr_amatch = 1'b0;
        chk(scl_oe == 1'b0, "R10 release after amatch clear", scl_oe, 0);
      end else if (auto_en && drdy) begin
        if (scl_oe) begin
          wait_n(HOLD);
          chk(scl_oe == 1'b1, "R6/R7 byte stretch held", scl_oe, 1);
          if (dir) begin
            tx_data = (tx_q.size() != 0) ? tx_q.pop_front() : 8'h00;
            tx_we = 1'b1;
            @(negedge clk);
            tx_we = 1'b0;
          end
          clr_drdy = 1'b1;
          @(negedge clk);
          clr_drdy = 1'b0;
          chk(scl_oe == 1'b0, "R10 release after drdy clear", scl_oe, 0);
        end else begin
          clr_drdy = 1'b1;
          @(negedge clk);
          clr_drdy = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor: received bytes
  initial begin
    logic prev;
    logic [7:0] e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (drdy && !prev && !dir) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected received byte", rx_data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rx_data == e, "R6 received byte", rx_data, e);
        end
      end
      prev = drdy;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit a;
    logic r;
    logic [7:0] d;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    // R1
    chk({scl_oe, sda_oe, amatch, drdy, stop_f, dir, coll} == 7'b0, "R1 reset state",
        {scl_oe, sda_oe, amatch, drdy, stop_f, dir, coll}, 0);
    auto_en = 1'b1;

    // R3 after-ack mode write
    stretch_after = 1'b1;
    exp_q.push_back(8'hA5);
    exp_q.push_back(8'h3C);
    m_start();
    m_write(8'h54, a); chk(a, "R3 address auto ACK", a, 1);
    m_write(8'hA5, a); chk(a, "R6 data ACK", a, 1);
    m_write(8'h3C, a); chk(a, "R6 data ACK", a, 1);
    m_stop();
    wait_n(6);
    chk(stop_f == 1'b1, "R8 stop flag", stop_f, 1);
    chk(dir == 1'b0, "R5 write direction", dir, 0);
    pulse_clr_stop();
    chk(stop_f == 1'b0, "R8 stop flag cleared", stop_f, 0);

    // R2 mismatch (read bit set)
    m_start();
    m_write(8'h23, a); chk(!a, "R2 mismatch NACK", a, 0);
    chk(amatch == 1'b0, "R2 no address flag", amatch, 0);
    chk(dir == 1'b0, "R5 dir unchanged on mismatch", dir, 0);
    m_write(8'h00, a); chk(!a && !drdy, "R2 data ignored", {a, drdy}, 0);
    m_stop();
    wait_n(6);
    chk(stop_f == 1'b0, "R2 no stop flag when unaddressed", stop_f, 0);

    // R4 before-ack mode read
    stretch_after = 1'b0;
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h5A);
    m_start();
    m_write(8'h55, a); chk(a, "R4 ACK after host command", a, 1);
    chk(dir == 1'b1, "R5 read direction", dir, 1);
    m_read(1'b1, d); chk(d == 8'hC3, "R7 first byte", d, 8'hC3);
    m_read(1'b0, d); chk(d == 8'h5A, "R7 second byte", d, 8'h5A);
    wait_n(6);
    chk(!sda_oe && !scl_oe, "R7 lines released after NACK", {sda_oe, scl_oe}, 0);
    m_read(1'b0, d); chk(d == 8'hFF, "R7 ignored after NACK", d, 8'hFF);

    // R11 repeated start into a write
    exp_q.push_back(8'h81);
    m_rstart();
    m_write(8'h54, a); chk(a, "R11 address after repeated START", a, 1);
    chk(dir == 1'b0, "R11 direction updated", dir, 0);
    m_write(8'h81, a); chk(a, "R6 data ACK", a, 1);
    m_stop();
    wait_n(6);
    chk(stop_f == 1'b1, "R8 stop flag after write", stop_f, 1);
    pulse_clr_stop();

    // R4 NACK action
    ack_nack = 1'b1;
    m_start();
    m_write(8'h54, a); chk(!a, "R4 NACK action", a, 0);
    m_stop();
    ack_nack = 1'b0;
    wait_n(6);
    pulse_clr_stop();

    // R9 collision
    tx_q.push_back(8'hFF);
    m_start();
    m_write(8'h55, a); chk(a, "R9 read address ACK", a, 1);
    m_bit(1'b0, r);
    wait_n(4);
    chk(coll == 1'b1, "R9 collision status", coll, 1);
    chk(!sda_oe && !scl_oe, "R9 lines released", {sda_oe, scl_oe}, 0);
    chk(!drdy && !amatch, "R9 no flag raised", {drdy, amatch}, 0);
    for (int i = 0; i < 8; i++) m_bit(1'b1, r);
    m_stop();
    wait_n(6);
    pulse_clr_stop();
    m_start();
    m_write(8'h54, a);
    m_stop();
    wait_n(6);
    chk(coll_at_match == 1'b1, "R9 collision visible at next match", coll_at_match, 1);
    chk(coll == 1'b0, "R9 collision cleared with amatch", coll, 0);
    pulse_clr_stop();

    chk(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule